// File: doc/BRIEF.md
# Multi-Standard Video Sync Generator

This block produces the complete set of horizontal and vertical timing signals for a colour video camera from one pixel-rate clock. A two-bit standard select picks one of four broadcast systems. A single horizontal counter divides each line into two half-lines. A vertical counter steps once per half-line, so an interlaced field can begin in the middle of a line. Every output is a registered decode of the next counter state, so an output changes on the same edge as the counter position it describes.

For genlock use, an external-sync enable lets three already-synchronised single-cycle strobes realign the counters. A horizontal strobe reloads the line position. A jitter window stops later strobes near the expected position from disturbing the timing. A vertical strobe restarts the field sequence at the next half-line boundary. A line-alternate strobe clears the half-line-rate square wave at the next line start.

Top module: `syncgen_top`

## Requirements
- R1: `sys_sel` selects the standard: 00 NTSC and 10 PAL-M use line length L = LINE_525 and N = LINES_525 lines per frame; 01 SECAM and 11 PAL use L = LINE_625 and N = LINES_625. `fh_o` is high for horizontal positions 0 to L/2-1 of each L-clock line. `f2h_o` is high in the first floor(L/4) clocks of each half-line, which gives twice the line rate.
- R2: The vertical counter counts 2N half-lines per frame. `field_odd_o` is high for half-lines 0 to N-1 and low for half-lines N to 2N-1. The even field therefore starts at mid-line.
- R3: Let k be the half-line index within the field and E = 6 for 525-line systems or 5 for 625-line systems. `vdrive_o` is high while k < 3E, which is 9 lines or 7.5 lines.
- R4: `cblank_o` is high while k < 40 (525-line systems) or k < 50 (625-line systems), which is 20 or 25 lines. It is also high at horizontal positions below L/6.
- R5: `csync_o` has equalising pulses of width W = floor(L/13)/2 (minimum 1) at each half-line start for k < E and for 2E <= k < 3E. It has broad pulses of half-line position below L/2 - floor(L/13) for E <= k < 2E. Otherwise it has a normal pulse at horizontal positions below floor(L/13).
- R6: `hdrive_o` is high at horizontal positions below L/10.
- R7: A 3-bit field counter advances at each field start. `first_field_o` is high for k < E in fields where the counter is 0 modulo 4 (NTSC, SECAM) or 0 modulo 8 (PAL, PAL-M).
- R8: `lalt_o` toggles at every line start in all four standards, including NTSC.
- R9: In SECAM `burst_o` equals `cblank_o`. In the other standards it is high for k >= 3E at horizontal positions from S = floor(L/13) + floor(L/13)/4 for max(1, floor(L/13)/2) clocks.
- R10: With `ext_en` high, the first `h_load` after `ext_en` rises moves the horizontal position to 0 on the next edge. A later `h_load` is absorbed when the current position is >= L-3 or <= 1, and reloads otherwise.
- R11: With `ext_en` high, a `v_load` is held until the next half-line boundary. There the vertical counter and the field counter both become 0.
- R12: With `ext_en` high, a `lalt_load` is held until the next line start. There `lalt_o` becomes 0 instead of toggling.
- R13: With `ext_en` low, `h_load`, `v_load` and `lalt_load` have no effect, and any pending load is discarded.
- R14: While `rst_n` is low at a clock edge, all outputs become 0. After release the horizontal position advances from 0, and the first outputs correspond to horizontal position 1 of half-line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_sel | input | 2 | Standard select (00 NTSC, 01 SECAM, 10 PAL-M, 11 PAL) |
| ext_en | input | 1 | External-sync enable for the load strobes |
| h_load | input | 1 | Horizontal realign strobe |
| v_load | input | 1 | Vertical realign strobe |
| lalt_load | input | 1 | Line-alternate realign strobe |
| csync_o | output | 1 | Composite sync, high during sync |
| hdrive_o | output | 1 | Horizontal drive |
| vdrive_o | output | 1 | Vertical drive |
| cblank_o | output | 1 | Composite blanking |
| field_odd_o | output | 1 | High in the odd (first) field of a frame |
| first_field_o | output | 1 | Colour-framing first-field marker |
| lalt_o | output | 1 | Half line-rate alternate |
| burst_o | output | 1 | Burst flag, or colour blanking in SECAM |
| fh_o | output | 1 | Line-rate square wave |
| f2h_o | output | 1 | Double line-rate square wave |

## Verification
The bench builds the block with 30- and 28-clock lines and 61- and 71-line frames instead of the broadcast values. A full eight-field colour-framing cycle then takes under 8,000 clocks per standard, so all four standards can run through complete first-field periods. The vertical intervals keep their broadcast lengths in half-lines, so the equalising, broad-pulse, drive and blanking boundaries are all reached inside each shortened field. The small line length also places the jitter window and the burst window only a few clocks apart, and the load strobes are timed against positions tracked by the reference model.

// File: rtl/syncgen_pkg.sv
// Shared types for the sync generator.
// Assumes: line lengths are even and frame line counts are odd.
package syncgen_pkg;

    localparam int CW = 16;

    typedef enum logic [1:0] {
        STD_NTSC  = 2'b00,
        STD_SECAM = 2'b01,
        STD_PALM  = 2'b10,
        STD_PAL   = 2'b11
    } std_sel_e;

    // Per-standard timing constants, all in clocks or half-lines.
    typedef struct packed {
        logic [CW-1:0] line_len;
        logic [CW-1:0] lines;
        logic [CW-1:0] hs_w;
        logic [CW-1:0] eq_w;
        logic [CW-1:0] hd_w;
        logic [CW-1:0] hb_w;
        logic [CW-1:0] bs_pos;
        logic [CW-1:0] bs_w;
        logic [CW-1:0] eq_n;
        logic [CW-1:0] vbl_n;
        logic          fld8;
        logic          colb;
    } std_cfg_t;

    // Derive one standard's constants from its line length and line count.
    function automatic std_cfg_t make_cfg(int len, int nlines, bit is625, bit fld8, bit colb);
        std_cfg_t c;
        int hs;
        hs         = len / 13;
        c.line_len = CW'(len);
        c.lines    = CW'(nlines);
        c.hs_w     = CW'(hs);
        c.eq_w     = CW'((hs / 2) > 0 ? hs / 2 : 1);
        c.hd_w     = CW'(len / 10);
        c.hb_w     = CW'(len / 6);
        c.bs_pos   = CW'(hs + hs / 4);
        c.bs_w     = CW'((hs / 2) > 0 ? hs / 2 : 1);
        c.eq_n     = is625 ? CW'(5) : CW'(6);
        c.vbl_n    = is625 ? CW'(50) : CW'(40);
        c.fld8     = fld8;
        c.colb     = colb;
        return c;
    endfunction

endpackage

// File: rtl/syncgen_hcnt.sv
// Horizontal position counter with jittered-load absorption.
// Assumes: h_load is a single-cycle strobe already in the clk domain.
module syncgen_hcnt #(
    parameter int HW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] len,
    input  logic          ext_en,
    input  logic          h_load,
    output logic [HW-1:0] hc_nxt,
    output logic          half_tick,
    output logic          line_tick
);

    logic [HW-1:0] hc_q;
    logic [HW-1:0] half;
    logic          h_lock_q;
    logic          wrap;
    logic          absorb;
    logic          do_load;

    assign half = len >> 1;

    // Decide between wrap, increment and reload, and flag the boundaries crossed.
    always_comb begin
        wrap      = (hc_q >= len - HW'(1));
        absorb    = (hc_q >= len - HW'(3)) || (hc_q <= HW'(1));
        do_load   = ext_en && h_load && (!h_lock_q || !absorb);
        if (do_load)   hc_nxt = '0;
        else if (wrap) hc_nxt = '0;
        else           hc_nxt = hc_q + HW'(1);
        half_tick = !do_load && (wrap || (hc_q == half - HW'(1)));
        line_tick = !do_load && wrap;
    end

    // Hold the position and the lock flag that marks the first load as taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hc_q     <= '0;
            h_lock_q <= 1'b0;
        end else begin
            hc_q     <= hc_nxt;
            h_lock_q <= ext_en && (h_lock_q || h_load);
        end
    end

    p_hc_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(len) |-> (hc_q < len));
    p_first_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_en && h_load && !h_lock_q) |=> (hc_q == '0));
    p_lock_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_en |=> !h_lock_q);

endmodule

// File: rtl/syncgen_vcnt.sv
// Half-line vertical counter, field counter and line-alternate flag.
// Assumes: half_tick and line_tick come from the horizontal counter.
module syncgen_vcnt #(
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] nlines,
    input  logic          ext_en,
    input  logic          v_load,
    input  logic          lalt_load,
    input  logic          half_tick,
    input  logic          line_tick,
    output logic [VW-1:0] vh_nxt,
    output logic [2:0]    fc_nxt,
    output logic          lalt_nxt
);

    logic [VW-1:0] vh_q;
    logic [2:0]    fc_q;
    logic          lalt_q;
    logic          v_pend_q;
    logic          l_pend_q;
    logic          v_pend_nxt;
    logic          l_pend_nxt;
    logic          v_take;
    logic          l_take;
    logic [VW-1:0] last_hl;

    assign last_hl = (nlines << 1) - VW'(1);
    assign v_take  = ext_en && (v_pend_q || v_load);
    assign l_take  = ext_en && (l_pend_q || lalt_load);

    // Step the half-line and field counts, apply pending loads at boundaries.
    always_comb begin
        vh_nxt     = vh_q;
        fc_nxt     = fc_q;
        lalt_nxt   = lalt_q;
        v_pend_nxt = v_take;
        l_pend_nxt = l_take;
        if (half_tick) begin
            if (v_take) begin
                vh_nxt     = '0;
                fc_nxt     = '0;
                v_pend_nxt = 1'b0;
            end else begin
                vh_nxt = (vh_q >= last_hl) ? '0 : vh_q + VW'(1);
                if ((vh_nxt == nlines) || (vh_nxt == '0))
                    fc_nxt = fc_q + 3'd1;
            end
        end
        if (line_tick) begin
            if (l_take) begin
                lalt_nxt   = 1'b0;
                l_pend_nxt = 1'b0;
            end else begin
                lalt_nxt = !lalt_q;
            end
        end
    end

    // Register the vertical state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vh_q     <= '0;
            fc_q     <= '0;
            lalt_q   <= 1'b0;
            v_pend_q <= 1'b0;
            l_pend_q <= 1'b0;
        end else begin
            vh_q     <= vh_nxt;
            fc_q     <= fc_nxt;
            lalt_q   <= lalt_nxt;
            v_pend_q <= v_pend_nxt;
            l_pend_q <= l_pend_nxt;
        end
    end

    p_vload_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (half_tick && v_take) |=> ((vh_q == '0) && (fc_q == '0)));
    p_lalt_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && !l_take) |=> (lalt_q != $past(lalt_q)));
    p_lalt_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && l_take) |=> !lalt_q);
    p_pend_drop_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_en |=> (!v_pend_q && !l_pend_q));

endmodule

// File: rtl/syncgen_shape.sv
// Decodes the next counter state into registered timing outputs.
// Assumes: the vertical intervals are shorter than a field.
module syncgen_shape #(
    parameter int HW = 10,
    parameter int VW = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  syncgen_pkg::std_cfg_t cfg,
    input  logic [HW-1:0]         hc_n,
    input  logic [VW-1:0]         vh_n,
    input  logic [2:0]            fc_n,
    input  logic                  lalt_n,
    output logic                  csync_o,
    output logic                  hdrive_o,
    output logic                  vdrive_o,
    output logic                  cblank_o,
    output logic                  field_odd_o,
    output logic                  first_field_o,
    output logic                  lalt_o,
    output logic                  burst_o,
    output logic                  fh_o,
    output logic                  f2h_o
);

    logic [HW-1:0] half, hp;
    logic [VW-1:0] nl, k, e1, e2, e3, vbl;
    logic          second, in_vert, cs_d, hd_d, bk_d, ff_d, bf_d;

    assign half = HW'(cfg.line_len) >> 1;
    assign nl   = VW'(cfg.lines);
    assign e1   = VW'(cfg.eq_n);
    assign e2   = VW'(2 * cfg.eq_n);
    assign e3   = VW'(3 * cfg.eq_n);
    assign vbl  = VW'(cfg.vbl_n);

    // Fold the counters into in-field half-line and in-half-line positions.
    always_comb begin
        second  = (vh_n >= nl);
        k       = second ? vh_n - nl : vh_n;
        hp      = (hc_n >= half) ? hc_n - half : hc_n;
        in_vert = (k < e3);
    end

    // Compose sync, drive, blanking, framing and burst for the next position.
    always_comb begin
        if ((k < e1) || ((k >= e2) && (k < e3)))
            cs_d = (hp < HW'(cfg.eq_w));
        else if (k < e2)
            cs_d = (hp < half - HW'(cfg.hs_w));
        else
            cs_d = (hc_n < HW'(cfg.hs_w));
        hd_d = (hc_n < HW'(cfg.hd_w));
        bk_d = (k < vbl) || (hc_n < HW'(cfg.hb_w));
        ff_d = (cfg.fld8 ? (fc_n == 3'd0) : (fc_n[1:0] == 2'd0)) && (k < e1);
        if (cfg.colb)
            bf_d = bk_d;
        else
            bf_d = !in_vert && (hc_n >= HW'(cfg.bs_pos)) &&
                   (hc_n < HW'(cfg.bs_pos) + HW'(cfg.bs_w));
    end

    // Register all outputs on the edge that moves the counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csync_o       <= 1'b0;
            hdrive_o      <= 1'b0;
            vdrive_o      <= 1'b0;
            cblank_o      <= 1'b0;
            field_odd_o   <= 1'b0;
            first_field_o <= 1'b0;
            lalt_o        <= 1'b0;
            burst_o       <= 1'b0;
            fh_o          <= 1'b0;
            f2h_o         <= 1'b0;
        end else begin
            csync_o       <= cs_d;
            hdrive_o      <= hd_d;
            vdrive_o      <= in_vert;
            cblank_o      <= bk_d;
            field_odd_o   <= !second;
            first_field_o <= ff_d;
            lalt_o        <= lalt_n;
            burst_o       <= bf_d;
            fh_o          <= (hc_n < half);
            f2h_o         <= (hp < (half >> 1));
        end
    end

    p_vd_in_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vdrive_o |-> cblank_o);
    p_ff_in_vd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        first_field_o |-> vdrive_o);
    p_f2h_with_fh_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fh_o) |-> f2h_o);

endmodule

// File: rtl/syncgen_top.sv
// Multi-standard sync generator: picks the standard constants and wires the
// horizontal counter, vertical counter and output decoder together.
// Assumes: load strobes are synchronous to clk and one cycle long.
module syncgen_top #(
    parameter int LINE_525  = 910,
    parameter int LINE_625  = 908,
    parameter int LINES_525 = 525,
    parameter int LINES_625 = 625
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sys_sel,
    input  logic       ext_en,
    input  logic       h_load,
    input  logic       v_load,
    input  logic       lalt_load,
    output logic       csync_o,
    output logic       hdrive_o,
    output logic       vdrive_o,
    output logic       cblank_o,
    output logic       field_odd_o,
    output logic       first_field_o,
    output logic       lalt_o,
    output logic       burst_o,
    output logic       fh_o,
    output logic       f2h_o
);
    import syncgen_pkg::*;

    localparam int LINE_MAX  = (LINE_525 > LINE_625) ? LINE_525 : LINE_625;
    localparam int LINES_MAX = (LINES_525 > LINES_625) ? LINES_525 : LINES_625;
    localparam int HW = $clog2(LINE_MAX + 1);
    localparam int VW = $clog2(2 * LINES_MAX + 1);

    localparam std_cfg_t C_NTSC  = make_cfg(LINE_525, LINES_525, 1'b0, 1'b0, 1'b0);
    localparam std_cfg_t C_SECAM = make_cfg(LINE_625, LINES_625, 1'b1, 1'b0, 1'b1);
    localparam std_cfg_t C_PALM  = make_cfg(LINE_525, LINES_525, 1'b0, 1'b1, 1'b0);
    localparam std_cfg_t C_PAL   = make_cfg(LINE_625, LINES_625, 1'b1, 1'b1, 1'b0);

    std_cfg_t      cfg;
    logic [HW-1:0] hc_nxt;
    logic [VW-1:0] vh_nxt;
    logic [2:0]    fc_nxt;
    logic          lalt_nxt;
    logic          half_tick;
    logic          line_tick;

    // Select the constant set for the chosen standard.
    always_comb begin
        case (std_sel_e'(sys_sel))
            STD_NTSC:  cfg = C_NTSC;
            STD_SECAM: cfg = C_SECAM;
            STD_PALM:  cfg = C_PALM;
            default:   cfg = C_PAL;
        endcase
    end

    syncgen_hcnt #(.HW(HW)) u_hcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .len       (HW'(cfg.line_len)),
        .ext_en    (ext_en),
        .h_load    (h_load),
        .hc_nxt    (hc_nxt),
        .half_tick (half_tick),
        .line_tick (line_tick)
    );

    syncgen_vcnt #(.VW(VW)) u_vcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .nlines    (VW'(cfg.lines)),
        .ext_en    (ext_en),
        .v_load    (v_load),
        .lalt_load (lalt_load),
        .half_tick (half_tick),
        .line_tick (line_tick),
        .vh_nxt    (vh_nxt),
        .fc_nxt    (fc_nxt),
        .lalt_nxt  (lalt_nxt)
    );

    syncgen_shape #(.HW(HW), .VW(VW)) u_shape (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg           (cfg),
        .hc_n          (hc_nxt),
        .vh_n          (vh_nxt),
        .fc_n          (fc_nxt),
        .lalt_n        (lalt_nxt),
        .csync_o       (csync_o),
        .hdrive_o      (hdrive_o),
        .vdrive_o      (vdrive_o),
        .cblank_o      (cblank_o),
        .field_odd_o   (field_odd_o),
        .first_field_o (first_field_o),
        .lalt_o        (lalt_o),
        .burst_o       (burst_o),
        .fh_o          (fh_o),
        .f2h_o         (f2h_o)
    );

endmodule

// File: tb/syncgen_top_test.sv
// Bench: behavioural reference model compared with every output on every clock.
module syncgen_top_test;

    localparam int L5 = 30;
    localparam int L6 = 28;
    localparam int N5 = 61;
    localparam int N6 = 71;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] sys_sel = 2'b00;
    logic ext_en = 1'b0, h_load = 1'b0, v_load = 1'b0, lalt_load = 1'b0;
    logic csync_o, hdrive_o, vdrive_o, cblank_o, field_odd_o;
    logic first_field_o, lalt_o, burst_o, fh_o, f2h_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    string phase = "";

    always #2 clk = ~clk;

    syncgen_top #(.LINE_525(L5), .LINE_625(L6), .LINES_525(N5), .LINES_625(N6)) uut (
        .clk(clk), .rst_n(rst_n), .sys_sel(sys_sel), .ext_en(ext_en),
        .h_load(h_load), .v_load(v_load), .lalt_load(lalt_load),
        .csync_o(csync_o), .hdrive_o(hdrive_o), .vdrive_o(vdrive_o),
        .cblank_o(cblank_o), .field_odd_o(field_odd_o),
        .first_field_o(first_field_o), .lalt_o(lalt_o), .burst_o(burst_o),
        .fh_o(fh_o), .f2h_o(f2h_o)
    );

    // Reference model state.
    int m_hc = 0, m_vh = 0, m_fc = 0, m_lalt = 0, m_lock = 0, m_vp = 0, m_lp = 0;
    bit e_cs, e_hd, e_vd, e_bk, e_od, e_ff, e_la, e_bf, e_fh, e_f2;

    always @(posedge clk) begin
        int L, N, H, HS, E, W, BS, BW, k, hp;
        bit f8, cb, ld, wr, ht, lt, vt, lt2;
        if (!rst_n) begin
            m_hc = 0; m_vh = 0; m_fc = 0; m_lalt = 0; m_lock = 0; m_vp = 0; m_lp = 0;
            {e_cs, e_hd, e_vd, e_bk, e_od, e_ff, e_la, e_bf, e_fh, e_f2} = '0;
        end else begin
            L  = sys_sel[0] ? L6 : L5;
            N  = sys_sel[0] ? N6 : N5;
            E  = sys_sel[0] ? 5 : 6;
            f8 = sys_sel[1];
            cb = (sys_sel == 2'b01);
            H  = L / 2;
            HS = L / 13;
            W  = (HS / 2 > 0) ? HS / 2 : 1;
            BS = HS + HS / 4;
            BW = W;
            wr = (m_hc >= L - 1);
            ld = ext_en && h_load && (!m_lock || !((m_hc >= L - 3) || (m_hc <= 1)));
            ht = !ld && (wr || m_hc == H - 1);
            lt = !ld && wr;
            m_hc = ld ? 0 : (wr ? 0 : m_hc + 1);
            m_lock = ext_en && (m_lock || h_load);
            vt  = ext_en && (m_vp || v_load);
            lt2 = ext_en && (m_lp || lalt_load);
            m_vp = vt;
            m_lp = lt2;
            if (ht) begin
                if (vt) begin m_vh = 0; m_fc = 0; m_vp = 0; end
                else begin
                    m_vh = (m_vh >= 2 * N - 1) ? 0 : m_vh + 1;
                    if (m_vh == N || m_vh == 0) m_fc = (m_fc + 1) % 8;
                end
            end
            if (lt) begin
                if (lt2) begin m_lalt = 0; m_lp = 0; end
                else m_lalt = 1 - m_lalt;
            end
            k  = (m_vh >= N) ? m_vh - N : m_vh;
            hp = (m_hc >= H) ? m_hc - H : m_hc;
            e_fh = (m_hc < H);
            e_f2 = (hp < H / 2);
            e_hd = (m_hc < L / 10);
            e_vd = (k < 3 * E);
            e_bk = (k < (sys_sel[0] ? 50 : 40)) || (m_hc < L / 6);
            if (k < E || (k >= 2 * E && k < 3 * E)) e_cs = (hp < W);
            else if (k < 2 * E) e_cs = (hp < H - HS);
            else e_cs = (m_hc < HS);
            e_od = (m_vh < N);
            e_ff = (f8 ? (m_fc == 0) : (m_fc % 4 == 0)) && (k < E);
            e_la = m_lalt[0];
            e_bf = cb ? e_bk : (k >= 3 * E && m_hc >= BS && m_hc < BS + BW);
        end
    end

    task automatic chk(input bit act, input bit exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s t=%0t actual=%b expected=%b", req, phase, $time, act, exp);
        end
    endtask

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk(fh_o,          e_fh, "R1 fh");
            chk(f2h_o,         e_f2, "R1 f2h");
            chk(field_odd_o,   e_od, "R2");
            chk(vdrive_o,      e_vd, "R3");
            chk(cblank_o,      e_bk, "R4");
            chk(csync_o,       e_cs, "R5");
            chk(hdrive_o,      e_hd, "R6");
            chk(first_field_o, e_ff, "R7");
            chk(lalt_o,        e_la, "R8");
            chk(burst_o,       e_bf, "R9");
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_hc(input int pos);
        while (m_hc != pos) @(negedge clk);
    endtask

    task automatic pulse_h();
        h_load = 1'b1; @(negedge clk); h_load = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired, actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R14: outputs held low in reset
        phase = "R14";
        cycles(3);
        chk(csync_o | hdrive_o | vdrive_o | cblank_o | field_odd_o, 1'b0, "R14 reset");
        chk(first_field_o | lalt_o | burst_o | fh_o | f2h_o, 1'b0, "R14 reset");
        // Free-run every standard over a full eight-field cycle.
        for (int m = 0; m < 4; m++) begin
            phase = (m == 0) ? "R1_ntsc" : (m == 1) ? "R9_secam" : (m == 2) ? "R7_palm" : "R2_pal";
            rst_n = 1'b0;
            sys_sel = m[1:0];
            cycles(2);
            rst_n = 1'b1;
            @(negedge clk);
            chk(fh_o, 1'b1, "R14 first position");
            chk(hdrive_o, 1'b1, "R14 first position");
            cycles(4 * (m[0] ? N6 * L6 : N5 * L5) + 40);
        end
        // Load strobes in NTSC.
        rst_n = 1'b0; sys_sel = 2'b00; cycles(2); rst_n = 1'b1;
        cycles(100);
        phase = "R10";
        ext_en = 1'b1;
        cycles(3);
        wait_hc(8);  pulse_h(); chk(hdrive_o, 1'b1, "R10 first load");
        cycles(2 * L5);
        wait_hc(L5 - 2); pulse_h(); chk(fh_o, 1'b0, "R10 absorbed");
        cycles(2 * L5);
        wait_hc(10); pulse_h(); chk(hdrive_o, 1'b1, "R10 reload");
        cycles(3 * L5);
        phase = "R11";
        wait_hc(5);
        v_load = 1'b1; @(negedge clk); v_load = 1'b0;
        cycles(N5 * L5 + 20);
        phase = "R12";
        wait_hc(4);
        lalt_load = 1'b1; @(negedge clk); lalt_load = 1'b0;
        cycles(4 * L5);
        phase = "R13";
        ext_en = 1'b0;
        @(negedge clk);
        wait_hc(8);
        h_load = 1'b1; v_load = 1'b1; lalt_load = 1'b1;
        @(negedge clk);
        h_load = 1'b0; v_load = 1'b0; lalt_load = 1'b0;
        chk(hdrive_o, 1'b0, "R13 ignored");
        ext_en = 1'b1;
        cycles(N5 * L5);
        finish_run();
    end

endmodule